// File: doc/BRIEF.md
# Tagged-Operand Reservation Station Pool

This block holds the operations waiting for one class of pipelined functional unit in an out-of-order core. Each accepted operation lands in a free station. For each source operand the station holds either the value or the tag of the station that will produce it. A tag of zero means the value is already present. The pool watches a single result broadcast bus. Every station that waits on the broadcast tag copies the value in the same cycle, which gives register renaming without extra copies of the register file.

When both operand tags of a station are zero, the station may be sent to the functional unit. Stations that become ready together are ordered by age, and at most one station is dispatched per cycle. A station remains occupied after dispatch and is freed only when the bus carries the station's own tag. Operations issued behind an unresolved branch carry a speculation mark. A flush discards the marked stations, and a resolve pulse clears the marks when the branch turns out not taken. For memory operations the dispatch port also supplies the effective address, formed as the first operand plus the immediate field.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `iss_tag` equals the lowest station tag (TAG_BASE, default 1), and `disp_valid` is 0.
- R2: An issue with both operand tags zero is dispatched in the next cycle with its opcode and values. `disp_tag` is TAG_BASE plus the station index, and the station chosen is the lowest-numbered free one.
- R3: A waiting station whose tag equals a valid broadcast tag takes the broadcast value. It may dispatch in the cycle after the broadcast.
- R4: A single broadcast wakes every station that waits on its tag, whether the wait is on the first or on the second operand.
- R5: An operand tag that matches a broadcast in the same cycle as issue is captured at issue. The station dispatches in the next cycle with the broadcast value.
- R6: At most one station is dispatched per cycle. Among the ready stations the oldest goes first, regardless of station index, and no station is dispatched twice.
- R7: When every station is occupied, `iss_ready` is 0 and an issue attempt changes no station.
- R8: A station is freed when a valid broadcast carries its own tag.
- R9: `flush` frees every occupied station that still carries the speculation mark (`iss_spec` = 1 at issue). `resolve` clears the mark on the stations that are occupied at that moment. No issue is accepted in a flush cycle.
- R10: `disp_addr` equals the dispatched first operand plus the immediate, modulo 2^DATA_W.
- R11: A broadcast whose tag matches no waiting operand leaves every waiting station unready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_vj | input | DATA_W | First operand value (used when iss_qj is 0) |
| iss_vk | input | DATA_W | Second operand value (used when iss_qk is 0) |
| iss_qj | input | TAG_W | Producer tag of the first operand, 0 if present |
| iss_qk | input | TAG_W | Producer tag of the second operand, 0 if present |
| iss_imm | input | DATA_W | Immediate / address offset field |
| iss_spec | input | 1 | Operation lies behind an unresolved branch |
| iss_ready | output | 1 | A station is free and an issue will be accepted |
| iss_tag | output | TAG_W | Tag that the next accepted issue will receive |
| cdb_valid | input | 1 | Broadcast bus carries a result |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| flush | input | 1 | Discard all speculative stations |
| resolve | input | 1 | Clear the speculation mark on occupied stations |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_op | output | OP_W | Dispatched opcode |
| disp_vj | output | DATA_W | Dispatched first operand |
| disp_vk | output | DATA_W | Dispatched second operand |
| disp_imm | output | DATA_W | Dispatched immediate |
| disp_addr | output | DATA_W | First operand plus immediate |
| disp_tag | output | TAG_W | Tag of the dispatched station |

## Verification
The bench checks age ordering with a case where the older ready station has the higher index. A picker that favoured low indices would send the younger operation first there. It checks a broadcast that arrives in the same cycle as the issue that needs it; a pool without that bypass would hang with the operand waiting forever. A single broadcast that wakes two stations through different operand fields shows whether both comparators are wired. A flush that follows a resolve shows whether the surviving branch mark was cleared or the wrong stations were dropped. Finally, an issue pushed at a full pool, and another pushed during a flush, must never reach the dispatch port.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int OP_W   = 6;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int AGE_W  = 4;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              spec;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] imm;
    } rs_slot_t;

    function automatic logic tag_hit(input logic v, input logic [TAG_W-1:0] bus,
                                     input logic [TAG_W-1:0] q);
        return v && (q != '0) && (q == bus);
    endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int NUM_RS = 4,
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  logic [NUM_RS-1:0] busy,
    output logic              any_free,
    output logic [IDX_W-1:0]  free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_select.sv
module rs_select import rs_pkg::*; #(
    parameter int NUM_RS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_RS-1:0]            ready,
    input  logic [NUM_RS-1:0][AGE_W-1:0] age,
    output logic [NUM_RS-1:0]            grant
);
    logic             found;
    logic [AGE_W-1:0] best_age;

    always_comb begin
        grant    = '0;
        found    = 1'b0;
        best_age = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (ready[i] && (!found || age[i] > best_age)) begin
                grant    = '0;
                grant[i] = 1'b1;
                found    = 1'b1;
                best_age = age[i];
            end
        end
    end

    p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_work_conserving_r6: assert property (@(posedge clk) disable iff (rst)
        (|ready) |-> (|grant));
endmodule

// File: rtl/rs_entry.sv
module rs_entry import rs_pkg::*; #(
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  rs_slot_t          wr_data,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              grant,
    input  logic              age_inc,
    input  logic              flush,
    input  logic              resolve,
    output logic              o_busy,
    output logic              o_ready,
    output logic [OP_W-1:0]   o_op,
    output logic [DATA_W-1:0] o_vj,
    output logic [DATA_W-1:0] o_vk,
    output logic [DATA_W-1:0] o_imm,
    output logic [AGE_W-1:0]  o_age
);
    rs_slot_t         st, nxt;
    logic [AGE_W-1:0] age, nage;
    logic             release_hit;

    assign release_hit = cdb_valid && (cdb_tag == MY_TAG);

    always_comb begin
        nxt  = st;
        nage = age;
        if (wr_en) begin
            nxt      = wr_data;
            nxt.busy = 1'b1;
            nxt.done = 1'b0;
            nage     = '0;
            if (tag_hit(cdb_valid, cdb_tag, wr_data.qj)) begin
                nxt.vj = cdb_value;
                nxt.qj = '0;
            end
            if (tag_hit(cdb_valid, cdb_tag, wr_data.qk)) begin
                nxt.vk = cdb_value;
                nxt.qk = '0;
            end
        end else if (st.busy) begin
            if (tag_hit(cdb_valid, cdb_tag, st.qj)) begin
                nxt.vj = cdb_value;
                nxt.qj = '0;
            end
            if (tag_hit(cdb_valid, cdb_tag, st.qk)) begin
                nxt.vk = cdb_value;
                nxt.qk = '0;
            end
            if (grant) nxt.done = 1'b1;
            if (age_inc && age != '1) nage = age + 1'b1;
            if (resolve) nxt.spec = 1'b0;
            if (release_hit || (flush && st.spec)) nxt.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            age <= '0;
        end else begin
            st  <= nxt;
            age <= nage;
        end
    end

    assign o_busy  = st.busy;
    assign o_ready = st.busy && !st.done && (st.qj == '0) && (st.qk == '0);
    assign o_op    = st.op;
    assign o_vj    = st.vj;
    assign o_vk    = st.vk;
    assign o_imm   = st.imm;
    assign o_age   = age;

    p_grant_only_ready_r6: assert property (@(posedge clk) disable iff (rst)
        grant |-> o_ready);
    p_no_second_dispatch_r6: assert property (@(posedge clk) disable iff (rst)
        grant |=> !o_ready);
    p_capture_value_r3: assert property (@(posedge clk) disable iff (rst)
        (st.busy && tag_hit(cdb_valid, cdb_tag, st.qj) && !release_hit && !(flush && st.spec))
        |=> (st.qj == '0) && (st.vj == $past(cdb_value)));
    p_flush_spec_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && st.busy && st.spec) |=> !st.busy);
    p_release_own_tag_r8: assert property (@(posedge clk) disable iff (rst)
        (st.busy && release_hit) |=> !st.busy);
endmodule

// File: rtl/rs_pool.sv
module rs_pool import rs_pkg::*; #(
    parameter int NUM_RS   = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_imm,
    input  logic              iss_spec,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              flush,
    input  logic              resolve,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [DATA_W-1:0] disp_imm,
    output logic [DATA_W-1:0] disp_addr,
    output logic [TAG_W-1:0]  disp_tag
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    logic [NUM_RS-1:0]             busy, ready, grant, wr_sel;
    logic [NUM_RS-1:0][AGE_W-1:0]  age;
    logic [NUM_RS-1:0][OP_W-1:0]   e_op;
    logic [NUM_RS-1:0][DATA_W-1:0] e_vj, e_vk, e_imm;
    logic                          any_free, accept;
    logic [IDX_W-1:0]              free_idx;
    rs_slot_t                      wr_data;

    rs_alloc #(.NUM_RS(NUM_RS)) u_alloc (
        .busy(busy), .any_free(any_free), .free_idx(free_idx)
    );

    assign iss_ready = any_free && !flush;
    assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
    assign accept    = iss_valid && iss_ready;

    always_comb begin
        wr_data      = '0;
        wr_data.spec = iss_spec;
        wr_data.op   = iss_op;
        wr_data.vj   = iss_vj;
        wr_data.vk   = iss_vk;
        wr_data.qj   = iss_qj;
        wr_data.qk   = iss_qk;
        wr_data.imm  = iss_imm;
    end

    for (genvar gi = 0; gi < NUM_RS; gi++) begin : g_rs
        assign wr_sel[gi] = accept && (free_idx == IDX_W'(gi));
        rs_entry #(.MY_TAG(TAG_W'(TAG_BASE + gi))) u_entry (
            .clk(clk), .rst(rst),
            .wr_en(wr_sel[gi]), .wr_data(wr_data),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
            .grant(grant[gi]), .age_inc(accept),
            .flush(flush), .resolve(resolve),
            .o_busy(busy[gi]), .o_ready(ready[gi]), .o_op(e_op[gi]),
            .o_vj(e_vj[gi]), .o_vk(e_vk[gi]), .o_imm(e_imm[gi]), .o_age(age[gi])
        );
    end

    rs_select #(.NUM_RS(NUM_RS)) u_select (
        .clk(clk), .rst(rst), .ready(ready), .age(age), .grant(grant)
    );

    always_comb begin
        disp_op  = '0;
        disp_vj  = '0;
        disp_vk  = '0;
        disp_imm = '0;
        disp_tag = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant[i]) begin
                disp_op  = disp_op  | e_op[i];
                disp_vj  = disp_vj  | e_vj[i];
                disp_vk  = disp_vk  | e_vk[i];
                disp_imm = disp_imm | e_imm[i];
                disp_tag = disp_tag | TAG_W'(TAG_BASE + i);
            end
        end
    end

    assign disp_valid = |grant;
    assign disp_addr  = disp_vj + disp_imm;

    p_full_blocks_issue_r7: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> ($countones(busy) <= $past($countones(busy))));
    p_flush_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && !(|(busy & ~ready))) |=> ($countones(busy) <= $past($countones(busy))));
endmodule

// File: tb/test_rs_pool.sv
module test_rs_pool;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid, iss_spec, cdb_valid, flush, resolve;
    logic [OP_W-1:0]   iss_op;
    logic [DATA_W-1:0] iss_vj, iss_vk, iss_imm, cdb_value;
    logic [TAG_W-1:0]  iss_qj, iss_qk, cdb_tag;
    logic              iss_ready, disp_valid;
    logic [TAG_W-1:0]  iss_tag, disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_vj, disp_vk, disp_imm, disp_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    rs_pool #(.NUM_RS(4), .TAG_BASE(1)) i_rs_pool (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_vk(iss_vk),
        .iss_qj(iss_qj), .iss_qk(iss_qk), .iss_imm(iss_imm), .iss_spec(iss_spec),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .flush(flush), .resolve(resolve),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk),
        .disp_imm(disp_imm), .disp_addr(disp_addr), .disp_tag(disp_tag)
    );

    always #2 clk = ~clk;

    task automatic idle();
        iss_valid = 0; iss_op = '0; iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
        iss_imm = '0; iss_spec = 0; cdb_valid = 0; cdb_tag = '0; cdb_value = '0;
        flush = 0; resolve = 0;
    endtask

    task automatic next();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int vj, input int vk, input int qj,
                         input int qk, input int imm, input bit spec);
        iss_valid = 1; iss_op = OP_W'(op); iss_vj = DATA_W'(vj); iss_vk = DATA_W'(vk);
        iss_qj = TAG_W'(qj); iss_qk = TAG_W'(qk); iss_imm = DATA_W'(imm); iss_spec = spec;
    endtask

    task automatic bcast(input int tag, input int val);
        cdb_valid = 1; cdb_tag = TAG_W'(tag); cdb_value = DATA_W'(val);
    endtask

    task automatic expect_none(input string req);
        chk(disp_valid == 1'b0, req, disp_valid, 0);
    endtask

    task automatic expect_disp(input string req, input int tag, input int vj, input int vk);
        chk(disp_valid == 1'b1, req, disp_valid, 1);
        chk(disp_tag == TAG_W'(tag), req, disp_tag, tag);
        chk(disp_vj == DATA_W'(vj), req, disp_vj, vj);
        chk(disp_vk == DATA_W'(vk), req, disp_vk, vk);
    endtask

    task automatic t_reset();
        settle();
        chk(iss_ready == 1'b1, "R1 ready", iss_ready, 1);
        chk(iss_tag == 4'd1, "R1 tag", iss_tag, 1);
        expect_none("R1 no dispatch");
    endtask

    task automatic t_basic();
        issue(5, 10, 20, 0, 0, 3, 0); settle();
        chk(iss_tag == 4'd1, "R2 lowest free", iss_tag, 1);
        next(); settle();
        expect_disp("R2 dispatch", 1, 10, 20);
        chk(disp_op == 6'd5, "R2 op", disp_op, 5);
        chk(disp_addr == 32'd13, "R10 address", disp_addr, 13);
        next(); settle();
        expect_none("R6 once");
        chk(iss_tag == 4'd2, "R2 next free", iss_tag, 2);
        bcast(1, 500);
        next(); settle();
        chk(iss_tag == 4'd1, "R8 freed", iss_tag, 1);
        next();
    endtask

    task automatic t_wake();
        issue(1, 0, 5, 9, 0, 0, 0); next();
        issue(2, 6, 0, 0, 9, 0, 0); settle(); expect_none("R3 waiting"); next();
        bcast(10, 1); settle(); expect_none("R11 wait"); next();
        settle(); expect_none("R11 other tag"); bcast(9, 77); next();
        settle(); expect_disp("R4 first", 1, 77, 5); next();
        settle(); expect_disp("R4 second", 2, 6, 77); bcast(1, 0); next();
        settle(); expect_none("R6 drained"); bcast(2, 0); next();
        next();
    endtask

    task automatic t_age();
        issue(3, 1, 1, 0, 0, 0, 0); next();
        issue(4, 0, 2, 9, 0, 0, 0); settle(); expect_disp("R2 P", 1, 1, 1); next();
        bcast(1, 0); settle(); expect_none("R6 Q waits"); next();
        issue(5, 0, 3, 9, 0, 0, 0); settle();
        chk(iss_tag == 4'd1, "R8 reuse", iss_tag, 1); next();
        bcast(9, 40); settle(); expect_none("R6 both wait"); next();
        settle(); expect_disp("R6 oldest first", 2, 40, 2); next();
        settle(); expect_disp("R6 younger next", 1, 40, 3); bcast(2, 0); next();
        bcast(1, 0); settle(); expect_none("R6 done"); next();
        next();
    endtask

    task automatic t_issue_capture();
        issue(7, 0, 2, 9, 0, 0, 0); bcast(9, 55); next();
        settle(); expect_disp("R5 bypass", 1, 55, 2); bcast(1, 0); next();
        settle(); expect_none("R5 after");
        chk(iss_tag == 4'd1, "R8 free", iss_tag, 1);
        next();
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) begin
            issue(10 + i, 0, i, 13, 0, 0, 0); settle();
            chk(iss_tag == TAG_W'(i + 1), "R2 fill order", iss_tag, i + 1);
            next();
        end
        settle();
        chk(iss_ready == 1'b0, "R7 full", iss_ready, 0);
        issue(63, 99, 99, 0, 0, 0, 0); next();
        settle();
        chk(iss_ready == 1'b0, "R7 still full", iss_ready, 0);
        expect_none("R7 ignored issue");
        bcast(13, 8); next();
        for (int i = 0; i < 4; i++) begin
            settle();
            expect_disp("R6 age order", i + 1, 8, i);
            chk(disp_op == OP_W'(10 + i), "R6 op", disp_op, 10 + i);
            next();
        end
        settle(); expect_none("R7 no ghost");
        for (int i = 0; i < 4; i++) begin
            bcast(i + 1, 0); next();
        end
        settle();
        chk(iss_ready == 1'b1, "R8 all free", iss_ready, 1);
        next();
    endtask

    task automatic t_flush();
        issue(1, 0, 1, 9, 0, 0, 0); next();
        issue(2, 0, 2, 9, 0, 0, 1); next();
        resolve = 1; next();
        issue(3, 0, 3, 9, 0, 0, 1); next();
        flush = 1; issue(4, 3, 3, 0, 0, 0, 1); settle();
        chk(iss_ready == 1'b0, "R9 flush blocks", iss_ready, 0);
        next();
        settle();
        chk(iss_tag == 4'd3, "R9 flushed slot free", iss_tag, 3);
        expect_none("R9 dropped issue");
        bcast(9, 21); next();
        settle(); expect_disp("R9 kept", 1, 21, 1); next();
        settle(); expect_disp("R9 resolved kept", 2, 21, 2); next();
        settle(); expect_none("R9 flushed gone"); bcast(1, 0); next();
        bcast(2, 0); next();
        settle(); chk(iss_tag == 4'd1, "R8 empty", iss_tag, 1);
        next();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_basic();
        t_wake();
        t_age();
        t_issue_capture();
        t_full();
        t_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule